// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Unit

This block holds the hardware debug-trap state of a processor core: four address slots, a control word that arms and classifies each slot, and a status word that records which slots matched. Every cycle the core presents the address of the instruction it is about to execute and, optionally, one data access with its address, byte count and direction. All slots are compared in parallel. Execution slots need an exact address match. Data slots match when the accessed bytes overlap the slot's aligned window.

A hit in an armed slot rewrites the low status bits and raises a one-cycle debug-exception pulse. A hit in a disarmed slot still appears in the status word, but only when the status word is rewritten for another reason. A single-step strobe forces that rewrite. A task-switch strobe disarms the locally armed slots. Software reaches the eight debug register numbers through a write port and a combinational read port. Status, control, slot registers and the exception pulse all change at the clock edge that samples the stimulus.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset, slots 0..3 read 0, status reads 0xFFFF0FF0 and control reads 0x00000400; dbg_exc is 0.
- R2: Register numbers 0..3 are the slots, 6 is status and 7 is control. Reads of 4 and 5 return status and control. Writes to 4 and 5 change nothing. A status write stores the value ORed with 0xFFFF0FF0.
- R3: Slot i is armed when control bits [2i+1:2i] are non-zero (low bit local, high bit global). Its kind is control bits [17+4i:16+4i] (0 execute, 1 data write, 2 I/O, 3 data read or write). Its length is control bits [19+4i:18+4i] (0 = 1 byte, 1 = 2 bytes, 2 = 8 bytes, 3 = 4 bytes).
- R4: A kind-0 slot matches in a cycle with ifetch_vld high and ifetch_addr equal to the slot address.
- R5: A kind-1 slot matches only writes (dacc_wr=1), a kind-3 slot matches any access, and a kind-2 slot never matches. A data match needs dacc_vld and an overlap between bytes dacc_addr .. dacc_addr+2^dacc_size-1 and the window that starts at the slot address with its low bits cleared to the length's alignment.
- R6: When at least one armed slot matches, status[3:0] at the next edge holds the match vector of all slots, armed or not. The other status bits are kept, and dbg_exc is 1 for that cycle.
- R7: In a cycle with no armed match and no single step, the status word (other than through a register write) does not change, and dbg_exc stays 0.
- R8: A single-step strobe forces the update: status[3:0] takes the match vector, status bit 14 is set and dbg_exc is raised.
- R9: A task-switch strobe clears control bits 0, 2, 4 and 6 and keeps every other control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Debug register number to write |
| reg_wr_data | input | 32 | Write value |
| reg_rd_sel | input | 3 | Debug register number to read |
| reg_rd_data | output | 32 | Read value (combinational) |
| ifetch_vld | input | 1 | Instruction address valid this cycle |
| ifetch_addr | input | ADDR_W | Address of the instruction about to execute |
| dacc_vld | input | 1 | Data access present this cycle |
| dacc_addr | input | ADDR_W | Data access start address |
| dacc_size | input | 2 | Access byte count as log2 (0..3 for 1..8 bytes) |
| dacc_wr | input | 1 | 1 for a write, 0 for a read |
| step_pulse | input | 1 | Single-step event |
| tswitch_pulse | input | 1 | Task-switch event |
| dbg_exc | output | 1 | Debug exception pulse, one cycle per triggering cycle |

## Verification
Directed patterns try each slot kind against a hit, a near miss one byte outside the window, and a mismatched direction. These cases separate the window masking for each length code, in particular the 8-byte code 2, from a plain address compare. Armed and disarmed slots that hit in the same cycle show that disarmed hits are recorded yet never trigger. A disarmed hit alone shows that the status word is left untouched. A single step that coincides with a disarmed hit shows that the forced update records it. Seeded random traffic over a small address range then mixes register writes, random control words, steps and task switches, and compares status and the exception pulse with a bench model after every cycle.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
   localparam int unsigned REG_W = 32;
   localparam logic [31:0] STAT_FIXED_ONES = 32'hFFFF_0FF0;
   localparam logic [31:0] CTRL_RESET_VAL  = 32'h0000_0400;
   localparam logic [31:0] CTRL_LOCAL_MASK = 32'h0000_0055;
   localparam int unsigned STAT_STEP_BIT   = 14;
   localparam int unsigned KIND_BASE       = 16;
   localparam int unsigned LEN_BASE        = 18;
   localparam int unsigned SLOT_STRIDE     = 4;

   typedef enum logic [1:0] {
      KIND_EXEC  = 2'd0,
      KIND_WRITE = 2'd1,
      KIND_IO    = 2'd2,
      KIND_RW    = 2'd3
   } slot_kind_e;

   typedef struct packed {
      logic [1:0] len;
      slot_kind_e kind;
      logic [1:0] arm;
   } slot_cfg_t;

   // byte span of a slot window from its length code
   function automatic logic [3:0] window_bytes(input logic [1:0] code);
      case (code)
         2'd0:    return 4'd1;
         2'd1:    return 4'd2;
         2'd2:    return 4'd8;
         default: return 4'd4;
      endcase
   endfunction

   // byte count of a data access from its log2 size
   function automatic logic [3:0] access_bytes(input logic [1:0] sz);
      return 4'd1 << sz;
   endfunction
endpackage

// File: rtl/dbg_slot_cmp.sv
module dbg_slot_cmp
   import dbg_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] slot_addr,
   input  slot_cfg_t         cfg,
   input  logic              ifetch_vld,
   input  logic [ADDR_W-1:0] ifetch_addr,
   input  logic              dacc_vld,
   input  logic [ADDR_W-1:0] dacc_addr,
   input  logic [1:0]        dacc_size,
   input  logic              dacc_wr,
   output logic              hit
);
   localparam int unsigned EW = ADDR_W + 1;

   logic [3:0]        win_span;
   logic [3:0]        acc_span;
   logic [ADDR_W-1:0] align_mask;
   logic [EW-1:0]     win_lo, win_hi, acc_lo, acc_hi;
   logic              overlap, dir_ok, exec_hit, data_hit;

   always_comb begin
      win_span   = window_bytes(cfg.len);
      acc_span   = access_bytes(dacc_size);
      align_mask = ~ADDR_W'(win_span - 4'd1);
      // one extra bit keeps the upper bounds from wrapping
      win_lo     = {1'b0, slot_addr & align_mask};
      win_hi     = win_lo + EW'(win_span - 4'd1);
      acc_lo     = {1'b0, dacc_addr};
      acc_hi     = acc_lo + EW'(acc_span - 4'd1);
      overlap    = (acc_lo <= win_hi) && (win_lo <= acc_hi);
      dir_ok     = (cfg.kind == KIND_RW) || ((cfg.kind == KIND_WRITE) && dacc_wr);
      exec_hit   = ifetch_vld && (cfg.kind == KIND_EXEC) && (slot_addr == ifetch_addr);
      data_hit   = dacc_vld && dir_ok && overlap;
      hit        = exec_hit || data_hit;
   end
endmodule

// File: rtl/dbg_regfile.sv
module dbg_regfile
   import dbg_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned NUM_SLOTS = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [2:0]                       wr_sel,
   input  logic [REG_W-1:0]                 wr_data,
   input  logic [2:0]                       rd_sel,
   output logic [REG_W-1:0]                 rd_data,
   input  logic                             tswitch,
   input  logic                             upd_en,
   input  logic [NUM_SLOTS-1:0]             upd_hits,
   input  logic                             upd_step,
   output logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_q,
   output logic [REG_W-1:0]                 ctrl_q,
   output logic [REG_W-1:0]                 stat_q
);
   localparam logic [2:0] SEL_STAT = 3'd6;
   localparam logic [2:0] SEL_CTRL = 3'd7;

   logic [REG_W-1:0] stat_nxt, ctrl_nxt;
   logic [3:0]       hits_ext;

   generate
      for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n)                            slot_q[g] <= '0;
            else if (wr_en && wr_sel == 3'(g))     slot_q[g] <= wr_data[ADDR_W-1:0];
         end
      end
      if (ADDR_W < REG_W) begin : g_wide_unused
         logic wr_hi_unused;
         assign wr_hi_unused = ^wr_data[REG_W-1:ADDR_W];
      end
   endgenerate

   assign hits_ext = 4'(upd_hits);

   always_comb begin
      stat_nxt = stat_q;
      if (wr_en && wr_sel == SEL_STAT) stat_nxt = wr_data | STAT_FIXED_ONES;
      // a check update lands on top of a same-cycle status write
      if (upd_en) begin
         stat_nxt[3:0] = hits_ext;
         if (upd_step) stat_nxt[STAT_STEP_BIT] = 1'b1;
      end
      ctrl_nxt = ctrl_q;
      if (wr_en && wr_sel == SEL_CTRL) ctrl_nxt = wr_data;
      if (tswitch) ctrl_nxt = ctrl_nxt & ~CTRL_LOCAL_MASK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= STAT_FIXED_ONES;
         ctrl_q <= CTRL_RESET_VAL;
      end else begin
         stat_q <= stat_nxt;
         ctrl_q <= ctrl_nxt;
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_sel)
         3'd4, SEL_STAT: rd_data = stat_q;
         3'd5, SEL_CTRL: rd_data = ctrl_q;
         default: begin
            for (int k = 0; k < NUM_SLOTS; k++)
               if (rd_sel == 3'(k)) rd_data = REG_W'(slot_q[k]);
         end
      endcase
   end

   // R2: fixed-one status bits never drop
   assert_stat_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q & STAT_FIXED_ONES) == STAT_FIXED_ONES);
   // R2: writes to the alias numbers leave control alone
   assert_alias_wr_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_sel == 3'd4 || wr_sel == 3'd5) && !tswitch) |=> $stable(ctrl_q));
   // R9: task switch leaves no local arm bit set
   assert_tswitch_local_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tswitch |=> ((ctrl_q & CTRL_LOCAL_MASK) == '0));
   // R9: global arm bits survive a task switch without a control write
   assert_tswitch_global_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tswitch && !(wr_en && wr_sel == SEL_CTRL)) |=> (ctrl_q[7:0] & 8'hAA) == ($past(ctrl_q[7:0]) & 8'hAA));
endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
   import dbg_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned NUM_SLOTS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [2:0]        reg_wr_sel,
   input  logic [31:0]       reg_wr_data,
   input  logic [2:0]        reg_rd_sel,
   output logic [31:0]       reg_rd_data,
   input  logic              ifetch_vld,
   input  logic [ADDR_W-1:0] ifetch_addr,
   input  logic              dacc_vld,
   input  logic [ADDR_W-1:0] dacc_addr,
   input  logic [1:0]        dacc_size,
   input  logic              dacc_wr,
   input  logic              step_pulse,
   input  logic              tswitch_pulse,
   output logic              dbg_exc
);
   generate
      if (NUM_SLOTS < 1 || NUM_SLOTS > 4) begin : g_bad_slots
         $error("NUM_SLOTS must be 1..4, the control layout has four fields");
      end
      if (ADDR_W < 4 || ADDR_W > REG_W) begin : g_bad_addr
         $error("ADDR_W must be 4..32");
      end
   endgenerate

   logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_q;
   logic [REG_W-1:0]                 ctrl_q, stat_q;
   slot_cfg_t                        cfg [NUM_SLOTS];
   logic [NUM_SLOTS-1:0]             hit_vec, arm_vec;
   logic                             armed_hit, upd_en, exc_q;
   logic                             ctrl_unused;

   assign ctrl_unused = ^ctrl_q[15:8];

   dbg_regfile #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr_en),
      .wr_sel   (reg_wr_sel),
      .wr_data  (reg_wr_data),
      .rd_sel   (reg_rd_sel),
      .rd_data  (reg_rd_data),
      .tswitch  (tswitch_pulse),
      .upd_en   (upd_en),
      .upd_hits (hit_vec),
      .upd_step (step_pulse),
      .slot_q   (slot_q),
      .ctrl_q   (ctrl_q),
      .stat_q   (stat_q)
   );

   generate
      for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
         assign cfg[g].arm  = ctrl_q[2*g +: 2];
         assign cfg[g].kind = slot_kind_e'(ctrl_q[KIND_BASE + SLOT_STRIDE*g +: 2]);
         assign cfg[g].len  = ctrl_q[LEN_BASE + SLOT_STRIDE*g +: 2];
         assign arm_vec[g]  = |cfg[g].arm;

         dbg_slot_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .slot_addr   (slot_q[g]),
            .cfg         (cfg[g]),
            .ifetch_vld  (ifetch_vld),
            .ifetch_addr (ifetch_addr),
            .dacc_vld    (dacc_vld),
            .dacc_addr   (dacc_addr),
            .dacc_size   (dacc_size),
            .dacc_wr     (dacc_wr),
            .hit         (hit_vec[g])
         );
      end
   endgenerate

   assign armed_hit = |(hit_vec & arm_vec);
   assign upd_en    = armed_hit || step_pulse;

   always_ff @(posedge clk) begin
      if (!rst_n) exc_q <= 1'b0;
      else        exc_q <= upd_en;
   end
   assign dbg_exc = exc_q;

   // R6: an exception always leaves a recorded cause in status
   assert_exc_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_exc |-> ((stat_q[3:0] != 4'd0) || stat_q[STAT_STEP_BIT]));
   // R6: an armed hit records its slot bit
   assert_armed_hit_recorded_R6: assert property (@(posedge clk) disable iff (!rst_n)
      armed_hit |=> (dbg_exc && ((stat_q[NUM_SLOTS-1:0] & $past(hit_vec & arm_vec)) == $past(hit_vec & arm_vec))));
   // R7: no armed hit and no step keeps status and the pulse quiet
   assert_quiet_check_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_pulse && !armed_hit && !(reg_wr_en && reg_wr_sel == 3'd6)) |=> ($stable(stat_q) && !dbg_exc));
   // R8: a single step sets the step cause and raises the pulse
   assert_step_forces_R8: assert property (@(posedge clk) disable iff (!rst_n)
      step_pulse |=> (dbg_exc && stat_q[STAT_STEP_BIT]));
endmodule

// File: tb/sim_dbg_match_unit.sv
module sim_dbg_match_unit;
   localparam logic [31:0] FIX = 32'hFFFF_0FF0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [2:0]  reg_wr_sel = 3'd0;
   logic [31:0] reg_wr_data = 32'd0;
   logic [2:0]  reg_rd_sel = 3'd6;
   logic [31:0] reg_rd_data;
   logic        ifetch_vld = 1'b0;
   logic [31:0] ifetch_addr = 32'd0;
   logic        dacc_vld = 1'b0;
   logic [31:0] dacc_addr = 32'd0;
   logic [1:0]  dacc_size = 2'd0;
   logic        dacc_wr = 1'b0;
   logic        step_pulse = 1'b0;
   logic        tswitch_pulse = 1'b0;
   logic        dbg_exc;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [31:0] m_slot [4];
   logic [31:0] m_ctrl, m_stat;

   always #10 clk = ~clk;

   dbg_match_unit u0 (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
      .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
      .ifetch_vld(ifetch_vld), .ifetch_addr(ifetch_addr),
      .dacc_vld(dacc_vld), .dacc_addr(dacc_addr), .dacc_size(dacc_size), .dacc_wr(dacc_wr),
      .step_pulse(step_pulse), .tswitch_pulse(tswitch_pulse), .dbg_exc(dbg_exc)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic longint win_len(input logic [1:0] c);
      case (c)
         2'd0: return 1;
         2'd1: return 2;
         2'd2: return 8;
         default: return 4;
      endcase
   endfunction

   // R3 R4 R5 model of one slot match from the current inputs
   function automatic bit m_hit(input int i);
      logic [1:0] kind = m_ctrl[16+4*i +: 2];
      longint L = win_len(m_ctrl[18+4*i +: 2]);
      longint wb, ab, asz;
      if (kind == 2'd0) return ifetch_vld && (m_slot[i] == ifetch_addr);
      if (kind == 2'd2 || !dacc_vld) return 1'b0;
      if (kind == 2'd1 && !dacc_wr) return 1'b0;
      wb  = longint'({32'd0, m_slot[i]}) & ~(L - 1);
      ab  = longint'({32'd0, dacc_addr});
      asz = longint'(1) << dacc_size;
      return (ab <= wb + L - 1) && (wb <= ab + asz - 1);
   endfunction

   task automatic idle();
      reg_wr_en = 1'b0; ifetch_vld = 1'b0; dacc_vld = 1'b0; dacc_wr = 1'b0;
      step_pulse = 1'b0; tswitch_pulse = 1'b0; reg_rd_sel = 3'd6;
   endtask

   // inputs set at the falling edge; one clock; compare with the model
   task automatic cyc(input string tag);
      logic [3:0]  h = 4'd0;
      bit          armed = 1'b0;
      logic [31:0] ns = m_stat, nc = m_ctrl;
      bit          exp_exc;
      for (int i = 0; i < 4; i++) begin
         h[i] = m_hit(i);
         if (h[i] && m_ctrl[2*i +: 2] != 2'd0) armed = 1'b1;
      end
      if (reg_wr_en) begin
         if (reg_wr_sel < 3'd4)  m_slot[reg_wr_sel[1:0]] = reg_wr_data;
         if (reg_wr_sel == 3'd6) ns = reg_wr_data | FIX;
         if (reg_wr_sel == 3'd7) nc = reg_wr_data;
      end
      if (tswitch_pulse) nc = nc & ~32'h55;
      exp_exc = armed || step_pulse;
      if (exp_exc) begin
         ns[3:0] = h;
         if (step_pulse) ns[14] = 1'b1;
      end
      reg_rd_sel = 3'd6;
      @(posedge clk);
      #2;
      m_stat = ns; m_ctrl = nc;
      chk({tag, " exc"}, 32'(dbg_exc), 32'(exp_exc));
      chk({tag, " status"}, reg_rd_data, m_stat);
      @(negedge clk);
      idle();
   endtask

   task automatic wr(input logic [2:0] sel, input logic [31:0] d, input string tag);
      reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
      cyc(tag);
   endtask

   task automatic rd(input logic [2:0] sel, input logic [31:0] exp, input string tag);
      reg_rd_sel = sel;
      #1;
      chk(tag, reg_rd_data, exp);
      reg_rd_sel = 3'd6;
   endtask

   task automatic fetch(input logic [31:0] a, input string tag);
      ifetch_vld = 1'b1; ifetch_addr = a;
      cyc(tag);
   endtask

   task automatic data(input logic [31:0] a, input logic [1:0] sz, input bit w, input string tag);
      dacc_vld = 1'b1; dacc_addr = a; dacc_size = sz; dacc_wr = w;
      cyc(tag);
   endtask

   function automatic string sum_line();
      return $sformatf("%0d/%0d checks passed", n_chk - n_bad, n_chk);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%s", sum_line());
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 4; i++) m_slot[i] = 32'd0;
      m_ctrl = 32'h0000_0400;
      m_stat = FIX;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state, R2 alias reads
      chk("R1 exc after reset", 32'(dbg_exc), 32'd0);
      for (int s = 0; s < 4; s++) rd(3'(s), 32'd0, "R1 slot reset");
      rd(3'd6, 32'hFFFF_0FF0, "R1 status reset");
      rd(3'd7, 32'h0000_0400, "R1 control reset");
      rd(3'd4, 32'hFFFF_0FF0, "R2 alias 4 reads status");
      rd(3'd5, 32'h0000_0400, "R2 alias 5 reads control");

      // R2 ignored alias writes and fixed-one status bits
      wr(3'd4, 32'h1234_5678, "R2 write 4");
      wr(3'd5, 32'h0BAD_F00D, "R2 write 5");
      rd(3'd6, 32'hFFFF_0FF0, "R2 status after alias writes");
      rd(3'd7, 32'h0000_0400, "R2 control after alias writes");
      wr(3'd6, 32'h0000_0000, "R2 status write zero");
      rd(3'd6, 32'hFFFF_0FF0, "R2 status fixed ones");

      // R4 execution slots, armed and disarmed
      wr(3'd0, 32'h0000_1000, "R4 slot0");
      wr(3'd7, 32'h0000_0401, "R3 arm slot0 local exec");
      fetch(32'h0000_1000, "R4 exec hit");
      rd(3'd6, 32'hFFFF_0FF1, "R6 status after exec hit");
      fetch(32'h0000_1001, "R4 exec near miss");
      wr(3'd1, 32'h0000_1000, "R4 slot1 disarmed same addr");
      fetch(32'h0000_1000, "R6 armed and disarmed hit");
      rd(3'd6, 32'hFFFF_0FF3, "R6 disarmed hit recorded");
      wr(3'd0, 32'h0000_1100, "R4 move slot0");
      fetch(32'h0000_1000, "R7 disarmed hit only");
      rd(3'd6, 32'hFFFF_0FF3, "R7 status unchanged");

      // R5 data write slot, 4-byte window, global arm
      wr(3'd2, 32'h0000_2004, "R5 slot2");
      wr(3'd7, 32'h0D00_0421, "R3 slot2 write 4B");
      data(32'h0000_2006, 2'd1, 1'b0, "R5 read ignored by write slot");
      data(32'h0000_2006, 2'd0, 1'b1, "R5 write hit");
      rd(3'd6, 32'hFFFF_0FF4, "R5 status after write hit");
      data(32'h0000_2003, 2'd1, 1'b1, "R5 straddling write hit");
      data(32'h0000_2008, 2'd0, 1'b1, "R5 miss above window");
      data(32'h0000_2002, 2'd1, 1'b1, "R5 miss below window");
      wr(3'd2, 32'h0000_2006, "R5 unaligned slot2");
      data(32'h0000_2004, 2'd0, 1'b1, "R5 aligned window hit");

      // R3 8-byte code 2 with read/write kind on slot3
      wr(3'd3, 32'h0000_3005, "R3 slot3");
      wr(3'd7, 32'hB000_0480, "R3 slot3 rw 8B");
      data(32'h0000_3000, 2'd0, 1'b0, "R3 8B window low byte");
      rd(3'd6, 32'hFFFF_0FF8, "R3 status slot3");
      data(32'h0000_3008, 2'd0, 1'b0, "R3 8B window miss");
      data(32'h0000_2FFF, 2'd3, 1'b0, "R5 8B access overlap");
      wr(3'd7, 32'hA000_0480, "R5 slot3 io kind");
      data(32'h0000_3005, 2'd0, 1'b1, "R5 io never matches");
      wr(3'd0, 32'h0000_4001, "R3 slot0 2B");
      wr(3'd7, 32'h0005_0402, "R3 slot0 global write 2B");
      data(32'h0000_4000, 2'd0, 1'b1, "R3 2B window hit");
      data(32'h0000_4002, 2'd0, 1'b1, "R3 2B window miss");

      // R8 single step, alone and with a disarmed hit
      step_pulse = 1'b1;
      cyc("R8 step alone");
      rd(3'd6, 32'hFFFF_4FF0, "R8 step status");
      wr(3'd7, 32'hB000_0400, "R7 slot3 disarmed rw");
      data(32'h0000_3005, 2'd0, 1'b1, "R7 disarmed data hit");
      dacc_vld = 1'b1; dacc_addr = 32'h0000_3005; dacc_size = 2'd0; dacc_wr = 1'b1;
      step_pulse = 1'b1;
      cyc("R8 step records disarmed hit");
      rd(3'd6, 32'hFFFF_4FF8, "R8 forced status");

      // R9 task switch
      wr(3'd7, 32'hFFFF_FFFF, "R9 all ones");
      tswitch_pulse = 1'b1;
      cyc("R9 task switch");
      rd(3'd7, 32'hFFFF_FFAA, "R9 local arms cleared");

      // seeded random traffic over a small address range
      for (int n = 0; n < 3000; n++) begin
         if ($urandom % 4 == 0) begin
            reg_wr_en  = 1'b1;
            reg_wr_sel = 3'($urandom % 8);
            reg_wr_data = (reg_wr_sel < 3'd4) ? (32'h100 + ($urandom % 48)) : $urandom;
         end
         ifetch_vld  = ($urandom % 2) == 0;
         ifetch_addr = 32'h100 + ($urandom % 48);
         dacc_vld    = ($urandom % 2) == 0;
         dacc_addr   = 32'h100 + ($urandom % 48);
         dacc_size   = 2'($urandom % 4);
         dacc_wr     = ($urandom % 2) == 0;
         step_pulse  = ($urandom % 16) == 0;
         tswitch_pulse = ($urandom % 16) == 0;
         cyc("R6 random");
         if (n % 64 == 0) rd(3'd7, m_ctrl, "R9 random control");
      end

      if (!done) begin
         done = 1'b1;
         $display("%s", sum_line());
         $finish;
      end
   end
endmodule